// File: doc/BRIEF.md
# I2S Audio Transmitter (Clock Master)

This block sends stereo audio to an external converter over an I2S-style serial link and acts as the clock master. It drives the converter's master clock, bit clock and word-select line, plus one serial data line. All three clocks come from a single free-running frame counter clocked by the system clock, so their phases never drift apart. The counter position decides which edge each clock takes next.

Samples arrive as a parallel left/right pair through a valid/ready handshake. The block takes a pair only at the start of a stereo frame. If no pair is offered at that moment, it sends the previous pair again. Each channel slot holds `SLOT_BITS` bit periods. The sample goes out most significant bit first and the rest of the slot is filled with zeros. A parameter sets where the MSB sits: either in the first bit period of the slot, together with the word-select change, or one bit period later.

At the default settings with a 100 MHz system clock, one bit-clock period is 50 system cycles (500 ns). A frame is 64 bit periods, which gives a 31.25 kHz sample rate. The master clock runs at 256 or 384 times the sample rate.

Top module: `i2s_tx`

## Requirements
- R1: While `rst` is high, `mst_clk`, `bit_clk`, `word_sel`, `ser_data` and `smp_ready` are all 0 and the stored sample pair is cleared. The first bit period after reset belongs to the left slot.
- R2: `bit_clk` is low for `HALF_CYCLES` system cycles and then high for `HALF_CYCLES` system cycles. The first bit period of a frame begins low. A frame lasts 4·`SLOT_BITS`·`HALF_CYCLES` cycles (3200 at the defaults).
- R3: `word_sel` is 0 during the left slot and 1 during the right slot. Each slot lasts `SLOT_BITS` bit periods. `word_sel` changes only on the system edge where `bit_clk` falls.
- R4: `ser_data` carries the sample MSB first, with zeros after the LSB up to the end of the slot. It changes only on the system edge where `bit_clk` falls.
- R5: With `ALIGN` = `ALIGN_MSB_AT_EDGE` (encoding 0), the MSB fills bit period 0 of each slot. With `ALIGN_MSB_DELAYED` (encoding 1), bit period 0 carries 0 and the MSB fills bit period 1. `SAMPLE_W` plus this delay must not exceed `SLOT_BITS`.
- R6: `mst_clk` makes exactly 2·`MCLK_RATIO` edges per frame (`MCLK_RATIO` is 256 or 384). After the edge that ends frame cycle c (counting from 0), its level is the parity of floor((c+1)·2·`MCLK_RATIO`/frame length). When the frame length is a multiple of 2·`MCLK_RATIO`, it is an exact square wave.
- R7: `smp_ready` is high for exactly one system cycle per frame: the cycle just before the left slot's first bit period appears on the outputs. A pair offered with `smp_valid` in that cycle is sent in that frame, left slot first. `smp_valid` in any other cycle is ignored.
- R8: If `smp_valid` is low in the `smp_ready` cycle, the frame sends the previously accepted pair again. After reset, the previously accepted pair is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Frame start; the offered pair is taken in this cycle |
| smp_left | input | SAMPLE_W | Left-channel sample, two's complement |
| smp_right | input | SAMPLE_W | Right-channel sample, two's complement |
| mst_clk | output | 1 | Master clock to the converter |
| bit_clk | output | 1 | Serial bit clock |
| word_sel | output | 1 | Channel select: 0 left, 1 right |
| ser_data | output | 1 | Serial sample data |

## Verification
The bench builds two configurations side by side.

The first uses a 4-cycle half period, 24-bit samples, 256x master clock and MSB at the edge. Its 512-cycle frame divides evenly by 512 master-clock edges, so it uses the plain-divider variant.

The second uses a 7-cycle half period, 16-bit samples, 384x master clock and the delayed MSB. Its 896-cycle frame forces the fractional-accumulator variant, and it exercises the delayed alignment and the wider zero padding.

The short half periods make ten frames per configuration cheap. This allows repeated frames, ignored out-of-window data and frame-boundary transitions to be compared every cycle against a behavioural model.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   typedef enum logic {
      ALIGN_MSB_AT_EDGE = 1'b0,
      ALIGN_MSB_DELAYED = 1'b1
   } align_e;

   // Single-cycle strobes decoded from the frame counter
   typedef struct packed {
      logic bit_fall;     // bit clock falls at the coming edge
      logic slot_start;   // first bit period of a slot starts
      logic frame_start;  // first bit period of the left slot starts
      logic frame_last;   // last system cycle of the frame
      logic right_slot;   // current slot is the right channel
   } tick_t;

   function automatic int lead_bits(input align_e a);
      return (a == ALIGN_MSB_DELAYED) ? 1 : 0;
   endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
   import i2s_tx_pkg::*;
#(
   parameter int HALF_CYCLES = 25,
   parameter int SLOT_BITS   = 32
)(
   input  logic  clk,
   input  logic  rst,
   output tick_t tick,
   output logic  bit_clk,
   output logic  word_sel
);
   localparam int HALVES = 4 * SLOT_BITS;
   localparam int HC_W   = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam int HI_W   = $clog2(HALVES);
   localparam logic [HC_W-1:0] HC_LAST  = HC_W'(HALF_CYCLES - 1);
   localparam logic [HI_W-1:0] HI_LAST  = HI_W'(HALVES - 1);
   localparam logic [HI_W-1:0] HI_RIGHT = HI_W'(2 * SLOT_BITS);

   logic [HC_W-1:0] hc_q;   // system cycle inside a bit-clock half
   logic [HI_W-1:0] hi_q;   // half index inside the frame
   logic            bclk_q;
   logic            ws_q;
   logic            hc_wrap;
   logic            hc_zero;

   assign hc_wrap = (hc_q == HC_LAST);
   assign hc_zero = (hc_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         hc_q   <= '0;
         hi_q   <= '0;
         bclk_q <= 1'b0;
         ws_q   <= 1'b0;
      end else begin
         hc_q <= hc_wrap ? '0 : hc_q + 1'b1;
         if (hc_wrap)
            hi_q <= (hi_q == HI_LAST) ? '0 : hi_q + 1'b1;
         bclk_q <= hi_q[0];
         ws_q   <= (hi_q >= HI_RIGHT);
      end
   end

   always_comb begin
      tick.bit_fall    = hc_zero && !hi_q[0];
      tick.slot_start  = hc_zero && ((hi_q == '0) || (hi_q == HI_RIGHT));
      tick.frame_start = hc_zero && (hi_q == '0);
      tick.frame_last  = hc_wrap && (hi_q == HI_LAST);
      tick.right_slot  = (hi_q >= HI_RIGHT);
   end

   assign bit_clk  = bclk_q;
   assign word_sel = ws_q;

   // R2: the bit clock holds its level except where a half period begins
   a_r2_half_hold: assert property (@(posedge clk) disable iff (rst)
      !hc_zero |=> $stable(bclk_q));

endmodule

// File: rtl/i2s_tx_mclk.sv
module i2s_tx_mclk #(
   parameter int FRAME_CYCLES = 3200,
   parameter int MCLK_RATIO   = 256
)(
   input  logic clk,
   input  logic rst,
   input  logic frame_last,
   output logic mst_clk
);
   localparam int EDGES = 2 * MCLK_RATIO;
   localparam int TC_W  = $clog2(EDGES + 1);

   logic tog;
   logic mclk_q;

   generate
      if (FRAME_CYCLES % EDGES == 0) begin : g_div
         localparam int Q  = FRAME_CYCLES / EDGES;
         localparam int DW = (Q > 1) ? $clog2(Q) : 1;
         localparam logic [DW-1:0] D_LAST = DW'(Q - 1);
         logic [DW-1:0] div_q;
         assign tog = (div_q == D_LAST);
         always_ff @(posedge clk) begin
            if (rst) div_q <= '0;
            else     div_q <= tog ? '0 : div_q + 1'b1;
         end
      end else begin : g_acc
         localparam int AW = $clog2(FRAME_CYCLES + EDGES) + 1;
         localparam logic [AW-1:0] STEP = AW'(EDGES);
         localparam logic [AW-1:0] LIM  = AW'(FRAME_CYCLES);
         logic [AW-1:0] acc_q;
         logic [AW-1:0] sum;
         assign sum = acc_q + STEP;
         assign tog = (sum >= LIM);
         always_ff @(posedge clk) begin
            if (rst) acc_q <= '0;
            else     acc_q <= tog ? sum - LIM : sum;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) mclk_q <= 1'b0;
      else     mclk_q <= mclk_q ^ tog;
   end

   assign mst_clk = mclk_q;

   // Edge tally per frame, used only by the check below
   logic [TC_W-1:0] tcnt_q;
   logic [TC_W-1:0] tcnt_next;
   assign tcnt_next = tcnt_q + TC_W'(tog);
   always_ff @(posedge clk) begin
      if (rst)             tcnt_q <= '0;
      else if (frame_last) tcnt_q <= '0;
      else                 tcnt_q <= tcnt_next;
   end

   // R6: exactly 2*MCLK_RATIO master-clock edges in every frame
   a_r6_edges_per_frame: assert property (@(posedge clk) disable iff (rst)
      frame_last |-> (tcnt_next == TC_W'(EDGES)));

endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold #(
   parameter int SAMPLE_W = 24
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                frame_start,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   output logic                smp_ready,
   output logic [SAMPLE_W-1:0] left_word,
   output logic [SAMPLE_W-1:0] right_word
);
   logic [SAMPLE_W-1:0] hold_l_q;
   logic [SAMPLE_W-1:0] hold_r_q;
   logic                accept;

   assign smp_ready = frame_start && !rst;
   assign accept    = smp_ready && smp_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_l_q <= '0;
         hold_r_q <= '0;
      end else if (accept) begin
         hold_l_q <= smp_left;
         hold_r_q <= smp_right;
      end
   end

   // The left slot loads in the accept cycle itself; the right one later
   assign left_word  = accept ? smp_left : hold_l_q;
   assign right_word = hold_r_q;

   // R7: ready is a single-cycle strobe
   a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
      smp_ready |=> !smp_ready);

   // R8: without an accept the stored pair is kept
   a_r8_pair_kept: assert property (@(posedge clk) disable iff (rst)
      !accept |=> ($stable(hold_l_q) && $stable(hold_r_q)));

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
   parameter int SAMPLE_W  = 24,
   parameter int SLOT_BITS = 32,
   parameter int LEAD      = 0
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                bit_fall,
   input  logic                slot_start,
   input  logic                right_slot,
   input  logic [SAMPLE_W-1:0] left_word,
   input  logic [SAMPLE_W-1:0] right_word,
   output logic                ser_data
);
   localparam int PAD = SLOT_BITS - SAMPLE_W - LEAD;

   logic [SLOT_BITS-1:0] sr_q;
   logic [SLOT_BITS-1:0] load_v;
   logic [SAMPLE_W-1:0]  word;

   assign word = right_slot ? right_word : left_word;

   generate
      if (LEAD > 0) begin : g_lead
         assign load_v = {{LEAD{1'b0}}, word, {PAD{1'b0}}};
      end else if (PAD > 0) begin : g_pad
         assign load_v = {word, {PAD{1'b0}}};
      end else begin : g_full
         assign load_v = word;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)             sr_q <= '0;
      else if (slot_start) sr_q <= load_v;
      else if (bit_fall)   sr_q <= {sr_q[SLOT_BITS-2:0], 1'b0};
   end

   assign ser_data = sr_q[SLOT_BITS-1];

   // R4: serial data moves only at bit-clock falling edges
   a_r4_data_on_fall: assert property (@(posedge clk) disable iff (rst)
      !bit_fall |=> $stable(sr_q[SLOT_BITS-1]));

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
   import i2s_tx_pkg::*;
#(
   parameter int     HALF_CYCLES = 25,
   parameter int     SLOT_BITS   = 32,
   parameter int     SAMPLE_W    = 24,
   parameter int     MCLK_RATIO  = 256,
   parameter align_e ALIGN       = ALIGN_MSB_AT_EDGE
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_valid,
   output logic                smp_ready,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   output logic                mst_clk,
   output logic                bit_clk,
   output logic                word_sel,
   output logic                ser_data
);
   localparam int LEAD         = lead_bits(ALIGN);
   localparam int FRAME_CYCLES = 4 * SLOT_BITS * HALF_CYCLES;

   generate
      if (HALF_CYCLES < 1) begin : g_bad_half
         $error("HALF_CYCLES must be at least 1");
      end
      if (SLOT_BITS < 2) begin : g_bad_slot
         $error("SLOT_BITS must be at least 2");
      end
      if (SAMPLE_W < 1 || SAMPLE_W + LEAD > SLOT_BITS) begin : g_bad_width
         $error("SAMPLE_W plus alignment delay must fit in a slot");
      end
      if (MCLK_RATIO != 256 && MCLK_RATIO != 384) begin : g_bad_ratio
         $error("MCLK_RATIO must be 256 or 384");
      end
      if (2 * MCLK_RATIO > FRAME_CYCLES) begin : g_bad_mclk
         $error("frame too short for the master clock ratio");
      end
   endgenerate

   tick_t               tick;
   logic [SAMPLE_W-1:0] left_word;
   logic [SAMPLE_W-1:0] right_word;

   i2s_tx_clkgen #(
      .HALF_CYCLES (HALF_CYCLES),
      .SLOT_BITS   (SLOT_BITS)
   ) u_clkgen (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .bit_clk  (bit_clk),
      .word_sel (word_sel)
   );

   i2s_tx_mclk #(
      .FRAME_CYCLES (FRAME_CYCLES),
      .MCLK_RATIO   (MCLK_RATIO)
   ) u_mclk (
      .clk        (clk),
      .rst        (rst),
      .frame_last (tick.frame_last),
      .mst_clk    (mst_clk)
   );

   i2s_tx_hold #(
      .SAMPLE_W (SAMPLE_W)
   ) u_hold (
      .clk         (clk),
      .rst         (rst),
      .frame_start (tick.frame_start),
      .smp_valid   (smp_valid),
      .smp_left    (smp_left),
      .smp_right   (smp_right),
      .smp_ready   (smp_ready),
      .left_word   (left_word),
      .right_word  (right_word)
   );

   i2s_tx_shifter #(
      .SAMPLE_W  (SAMPLE_W),
      .SLOT_BITS (SLOT_BITS),
      .LEAD      (LEAD)
   ) u_shift (
      .clk        (clk),
      .rst        (rst),
      .bit_fall   (tick.bit_fall),
      .slot_start (tick.slot_start),
      .right_slot (tick.right_slot),
      .left_word  (left_word),
      .right_word (right_word),
      .ser_data   (ser_data)
   );

   // R3: word select changes only together with a falling bit clock
   a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
      !$stable(word_sel) |-> $fell(bit_clk));

endmodule

// File: tb/i2s_tx_tb.sv
module i2s_tx_tb_core #(
   parameter int                  HALF    = 4,
   parameter int                  SLOT    = 32,
   parameter int                  W       = 24,
   parameter int                  RATIO   = 256,
   parameter i2s_tx_pkg::align_e  ALIGN   = i2s_tx_pkg::ALIGN_MSB_AT_EDGE,
   parameter int                  NFRAMES = 10
)(
   input  logic clk,
   input  logic rst,
   output int   n_chk,
   output int   n_err,
   output logic done
);
   localparam int FRAME = 4 * SLOT * HALF;
   localparam int DLY   = (ALIGN == i2s_tx_pkg::ALIGN_MSB_DELAYED) ? 1 : 0;

   logic         vld, rdy, mck, bck, ws, sd;
   logic [W-1:0] lft, rgt;
   logic [W-1:0] cur_l, cur_r;
   bit           rep;

   i2s_tx #(
      .HALF_CYCLES (HALF),
      .SLOT_BITS   (SLOT),
      .SAMPLE_W    (W),
      .MCLK_RATIO  (RATIO),
      .ALIGN       (ALIGN)
   ) u_dut (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (vld),
      .smp_ready (rdy),
      .smp_left  (lft),
      .smp_right (rgt),
      .mst_clk   (mck),
      .bit_clk   (bck),
      .word_sel  (ws),
      .ser_data  (sd)
   );

   function automatic logic [W-1:0] pat(input int f, input bit right);
      logic [31:0] h;
      if (f == 0) return right ? '0 : '1;
      if (f == 1) return right ? W'(1) : (W'(1) << (W - 1));
      h = (f * 32'h9E37_79B1) ^ (right ? 32'h5A5A_1234 : 32'h0F0F_A5C3);
      h = h ^ (h >> 13);
      return h[W-1:0];
   endfunction

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %b expected %b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   // Expected outputs after the edge that ended frame cycle pos
   task automatic check_outputs(input int pos);
      int hi, k, s, b, p;
      logic [W-1:0] word;
      logic e;
      string tg;
      hi = pos / HALF;
      chk("R2", "bit_clk", bck, logic'(hi % 2));
      chk("R3", "word_sel", ws, hi >= 2 * SLOT);
      k = hi / 2;
      s = k / SLOT;
      b = k % SLOT;
      p = b - DLY;
      word = (s != 0) ? cur_r : cur_l;
      e = (p >= 0 && p < W) ? word[W-1-p] : 1'b0;
      tg = rep ? "R8" : ((b <= 1) ? "R5" : "R4");
      chk(tg, "ser_data", sd, e);
      chk("R6", "mst_clk", mck, logic'((((pos + 1) * 2 * RATIO) / FRAME) % 2));
   endtask

   initial begin
      int  cs;
      int  nf;
      bit  first;
      n_chk = 0; n_err = 0; done = 1'b0;
      vld = 1'b0; lft = '0; rgt = '0;
      cur_l = '0; cur_r = '0; rep = 1'b0;
      repeat (4) begin
         @(negedge clk);
         chk("R1", "mst_clk", mck, 1'b0);
         chk("R1", "bit_clk", bck, 1'b0);
         chk("R1", "word_sel", ws, 1'b0);
         chk("R1", "ser_data", sd, 1'b0);
         chk("R1", "smp_ready", rdy, 1'b0);
      end
      wait (!rst);
      vld = 1'b1; lft = pat(0, 1'b0); rgt = pat(0, 1'b1);
      @(negedge clk);
      cs = 0; nf = 0; first = 1'b1;
      while (nf <= NFRAMES) begin
         if (!first) check_outputs((cs + FRAME - 1) % FRAME);
         first = 1'b0;
         chk("R7", "smp_ready", rdy, cs == 0);
         if (cs == 0) begin
            if (vld) begin cur_l = lft; cur_r = rgt; rep = 1'b0; end
            else rep = 1'b1;
            nf++;
         end
         if (cs == 1) begin
            // outside the ready cycle: change data under valid, then drop valid
            vld = 1'b0; lft = ~lft; rgt = rgt ^ W'(5);
         end
         if (cs == FRAME / 4) begin
            vld = 1'b1;  // R7: offered mid-frame, must wait for frame start
         end
         if (cs == FRAME / 4 + 1) vld = 1'b0;
         if (cs == FRAME / 2 && (nf % 4) != 2) begin
            vld = 1'b1; lft = pat(nf, 1'b0); rgt = pat(nf, 1'b1);
         end
         @(negedge clk);
         cs = (cs + 1) % FRAME;
      end
      done = 1'b1;
   end

endmodule

module i2s_tx_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   int   chk_a, err_a, chk_b, err_b;
   logic done_a, done_b;

   always #10 clk = ~clk;

   i2s_tx_tb_core #(
      .HALF (4), .W (24), .RATIO (256),
      .ALIGN (i2s_tx_pkg::ALIGN_MSB_AT_EDGE), .NFRAMES (10)
   ) u_edge (
      .clk (clk), .rst (rst), .n_chk (chk_a), .n_err (err_a), .done (done_a)
   );

   i2s_tx_tb_core #(
      .HALF (7), .W (16), .RATIO (384),
      .ALIGN (i2s_tx_pkg::ALIGN_MSB_DELAYED), .NFRAMES (10)
   ) u_dly (
      .clk (clk), .rst (rst), .n_chk (chk_b), .n_err (err_b), .done (done_b)
   );

   initial begin
      repeat (6) @(posedge clk);
      #3;
      rst = 1'b0;
   end

   initial begin
      int cyc;
      int wd;
      cyc = 0;
      wd  = 0;
      while (!(done_a === 1'b1 && done_b === 1'b1) && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!(done_a === 1'b1 && done_b === 1'b1)) begin
         wd = 1;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      end
      #1;
      $display("Simulation finished: %0d checks, %0d errors", chk_a + chk_b + wd, err_a + err_b + wd);
      $finish;
   end

endmodule